// File: doc/BRIEF.md
# Dual-Inverter Pole Reference Calculator

This block turns three signed phase-voltage demands for a series compensator into pole-voltage references for two inverters. The inverters feed the two ends of open-ended injection transformer windings. Each inverter has its own dc link. The two links may differ in voltage.

The block first picks a fourth-wire difference voltage between the inverter midpoints. It then forms one difference voltage per leg. For each leg it finds the free common-mode offset that keeps both inverters inside their link limits, and places that offset between its bounds using a mixing weight. A mode input selects one of three topologies:
- four legs on both inverters;
- four legs on inverter A and a split-capacitor inverter B;
- split capacitors on both inverters.

Operands enter through a valid/ready handshake and are registered. A sequencer then walks the computation through four register stages. It holds the result on a valid/ready output port until it is taken. The sequencer states, in order, are:

| State | Action | Transition |
|---|---|---|
| IDLE | accepts | leaves when `in_valid` is high |
| VR4 | fourth-wire difference | always goes to VRK |
| VRK | leg differences | always goes to BND |
| BND | offset bounds | always goes to MIX |
| MIX | interpolation and clamp | always goes to OUT |
| OUT | presents the result | returns to IDLE when `out_ready` is high |

Top module: `dual_inv_pole_ref`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and `va_ref`, `vb_ref`, `leg_en_a` and `leg_en_b` are all zero.
- R2: Each accepted input (`in_valid` and `in_ready` high at a clock edge) yields exactly one result, in acceptance order. `in_ready` is 0 from the edge after acceptance until the result is taken. `out_valid` and `in_ready` are never both 1. While `out_valid` is high and `out_ready` is low, the outputs stay unchanged.
- R3: `out_valid` rises at the fifth rising clock edge after the acceptance edge.
- R4: Interpolation between `lo` and `hi` with a 16-bit weight `m` gives `hi` when `m` is 0xFFFF. Otherwise it gives `lo + floor(m*(hi-lo)/65536)`.
- R5: Let `ha = floor(vdc_a/2)`, `hb = floor(vdc_b/2)` and `avg = floor((vdc_a+vdc_b)/2)`. In mode 0, the fourth-wire voltage `r4` interpolates with `mu_r4` between two bounds:
  - lower bound `-avg - min(p1,p2,p3,0)`;
  - upper bound `avg - max(p1,p2,p3,0)`.
- R6: In mode 1 the min and max are taken over the three phases only. The lower bound is then raised to at least `-ha`, and the upper bound is cut to at most `ha`.
- R7: In modes 2 and 3, `r4` is 0. Leg differences are `rk = pk + r4` for k = 1..3, and `r4` itself for leg 4.
- R8: Per leg, with `h = floor(rk/2)`:
  - the offset `x` interpolates with that leg's `mu_x` field between `max(-ha-h, -hb+h)` and `min(ha-h, hb+h)`;
  - `va = h + x` and `vb = x - h`.
- R9: Every `va` lies in `[-ha, ha]` and every `vb` in `[-hb, hb]`; values outside are clamped to the nearer limit.
- R10: Leg 4 depends on the mode:
  - mode 0: leg 4 is computed like the others;
  - mode 1: `va` of leg 4 is `r4` clamped to ±`ha`, and `vb` of leg 4 is 0;
  - modes 2 and 3: both leg-4 outputs are 0.
- R11: Leg enables (bit k-1 = leg k) depend on the mode:
  - mode 0: `leg_en_a` = 1111 and `leg_en_b` = 1111;
  - mode 1: `leg_en_a` = 1111 and `leg_en_b` = 0111;
  - modes 2 and 3: `leg_en_a` = 0111 and `leg_en_b` = 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| in_valid | input | 1 | operands offered |
| in_ready | output | 1 | block idle and accepting |
| mode | input | 2 | 0 four/four, 1 four/split, 2 and 3 split/split |
| vp_ref | input | 3*W | signed phase demands, phase j at bits [j*W +: W] |
| vdc_a | input | W | dc-link reference of inverter A (non-negative) |
| vdc_b | input | W | dc-link reference of inverter B (non-negative) |
| mu_r4 | input | MUW | fourth-wire weight, unsigned fraction |
| mu_x | input | 4*MUW | per-leg offset weights, leg k at bits [k*MUW +: MUW] |
| out_valid | output | 1 | result present |
| out_ready | input | 1 | consumer takes the result |
| va_ref | output | 4*W | inverter A pole references, leg k at [k*W +: W] |
| vb_ref | output | 4*W | inverter B pole references, leg k at [k*W +: W] |
| leg_en_a | output | 4 | active legs of inverter A |
| leg_en_b | output | 4 | active legs of inverter B |

## Verification
The assertions assume the following about the inputs:
- Both dc-link references are non-negative, so the captured half-link limits are valid clamp bounds.
- The consumer only ever lowers `out_ready` while a result waits; it never relies on a result being dropped.

The stimulus keeps to these assumptions. Every link value is between 0 and 32767, and `out_ready` toggles freely. Phase demands cover the full signed range, including cases where the bounds cross and only the output clamp keeps the limits.

// File: rtl/dual_inv_pkg.sv
package dual_inv_pkg;

    localparam int NUM_PHASE = 3;
    localparam int NUM_LEG   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VR4,
        ST_VRK,
        ST_BND,
        ST_MIX,
        ST_OUT
    } seq_state_t;

    typedef enum logic [1:0] {
        MD_FOUR_FOUR   = 2'd0,
        MD_FOUR_SPLIT  = 2'd1,
        MD_SPLIT_SPLIT = 2'd2,
        MD_SPLIT_ALT   = 2'd3
    } leg_mode_t;

endpackage

// File: rtl/dual_inv_interp.sv
module dual_inv_interp #(
    parameter int IW  = 19,
    parameter int MUW = 16
) (
    input  logic signed [IW-1:0]  lo,
    input  logic signed [IW-1:0]  hi,
    input  logic        [MUW-1:0] mu,
    output logic signed [IW-1:0]  y
);
    localparam int DW = IW + 1;
    localparam int PW = DW + MUW + 1;

    logic signed [DW-1:0] span;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] step;

    always_comb begin
        span = DW'(hi) - DW'(lo);
        prod = PW'(span) * PW'($signed({1'b0, mu}));
        step = prod >>> MUW;
        if (&mu) begin
            y = hi;
        end else begin
            y = lo + IW'(step);
        end
    end
endmodule

// File: rtl/dual_inv_vr4.sv
module dual_inv_vr4
    import dual_inv_pkg::*;
#(
    parameter int W   = 16,
    parameter int IW  = 19,
    parameter int MUW = 16
) (
    input  leg_mode_t               mode,
    input  logic [NUM_PHASE*W-1:0]  vp,
    input  logic [W-1:0]            vca,
    input  logic [W-1:0]            vcb,
    input  logic [MUW-1:0]          mu,
    output logic signed [IW-1:0]    r4
);
    logic signed [IW-1:0] pe [NUM_PHASE];
    logic signed [IW-1:0] ha, avg, mn, mx, lo, hi, mixed;

    always_comb begin
        for (int j = 0; j < NUM_PHASE; j++) begin
            pe[j] = IW'($signed(vp[j*W +: W]));
        end
        ha  = IW'($signed(vca)) >>> 1;
        avg = (IW'($signed(vca)) + IW'($signed(vcb))) >>> 1;
        mn  = pe[0];
        mx  = pe[0];
        for (int j = 1; j < NUM_PHASE; j++) begin
            if (pe[j] < mn) mn = pe[j];
            if (pe[j] > mx) mx = pe[j];
        end
        if (mode == MD_FOUR_FOUR) begin
            if (mn > 0) mn = '0;
            if (mx < 0) mx = '0;
        end
        lo = -avg - mn;
        hi = avg - mx;
        if (mode == MD_FOUR_SPLIT) begin
            if (lo < -ha) lo = -ha;
            if (hi > ha)  hi = ha;
        end
    end

    dual_inv_interp #(.IW(IW), .MUW(MUW)) u_mix (
        .lo (lo),
        .hi (hi),
        .mu (mu),
        .y  (mixed)
    );

    always_comb begin
        if (mode == MD_FOUR_FOUR || mode == MD_FOUR_SPLIT) begin
            r4 = mixed;
        end else begin
            r4 = '0;
        end
    end
endmodule

// File: rtl/dual_inv_leg_bounds.sv
module dual_inv_leg_bounds #(
    parameter int W  = 16,
    parameter int IW = 19
) (
    input  logic signed [IW-1:0] rk,
    input  logic signed [W-1:0]  ha,
    input  logic signed [W-1:0]  hb,
    output logic signed [IW-1:0] hr,
    output logic signed [IW-1:0] lo,
    output logic signed [IW-1:0] hi
);
    logic signed [IW-1:0] hae, hbe, lo_a, lo_b, hi_a, hi_b;

    always_comb begin
        hae  = IW'(ha);
        hbe  = IW'(hb);
        hr   = rk >>> 1;
        lo_a = -hae - hr;
        lo_b = -hbe + hr;
        hi_a = hae - hr;
        hi_b = hbe + hr;
        lo   = (lo_a > lo_b) ? lo_a : lo_b;
        hi   = (hi_a < hi_b) ? hi_a : hi_b;
    end
endmodule

// File: rtl/dual_inv_leg_mix.sv
module dual_inv_leg_mix #(
    parameter int W   = 16,
    parameter int IW  = 19,
    parameter int MUW = 16
) (
    input  logic signed [IW-1:0] lo,
    input  logic signed [IW-1:0] hi,
    input  logic signed [IW-1:0] hr,
    input  logic        [MUW-1:0] mu,
    input  logic signed [W-1:0]  ha,
    input  logic signed [W-1:0]  hb,
    output logic signed [W-1:0]  va,
    output logic signed [W-1:0]  vb
);
    logic signed [IW-1:0] x, sum_a, sum_b, hae, hbe;

    dual_inv_interp #(.IW(IW), .MUW(MUW)) u_off (
        .lo (lo),
        .hi (hi),
        .mu (mu),
        .y  (x)
    );

    always_comb begin
        hae   = IW'(ha);
        hbe   = IW'(hb);
        sum_a = hr + x;
        sum_b = x - hr;
        if (sum_a > hae)       va = ha;
        else if (sum_a < -hae) va = -ha;
        else                   va = W'(sum_a);
        if (sum_b > hbe)       vb = hb;
        else if (sum_b < -hbe) vb = -hb;
        else                   vb = W'(sum_b);
    end
endmodule

// File: rtl/dual_inv_pole_ref.sv
module dual_inv_pole_ref
    import dual_inv_pkg::*;
#(
    parameter int W   = 16,
    parameter int MUW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [1:0]                mode,
    input  logic [NUM_PHASE*W-1:0]    vp_ref,
    input  logic [W-1:0]              vdc_a,
    input  logic [W-1:0]              vdc_b,
    input  logic [MUW-1:0]            mu_r4,
    input  logic [NUM_LEG*MUW-1:0]    mu_x,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [NUM_LEG*W-1:0]      va_ref,
    output logic [NUM_LEG*W-1:0]      vb_ref,
    output logic [NUM_LEG-1:0]        leg_en_a,
    output logic [NUM_LEG-1:0]        leg_en_b
);
    localparam int IW = W + 3;

    seq_state_t state, state_nx;

    leg_mode_t                 mode_q;
    logic [NUM_PHASE*W-1:0]    vp_q;
    logic [W-1:0]              vca_q, vcb_q;
    logic [MUW-1:0]            mur4_q;
    logic [NUM_LEG*MUW-1:0]    mux_q;
    logic signed [IW-1:0]      r4_q;
    logic signed [IW-1:0]      rk_q [NUM_LEG];
    logic signed [IW-1:0]      lo_q [NUM_LEG];
    logic signed [IW-1:0]      hi_q [NUM_LEG];
    logic signed [IW-1:0]      hr_q [NUM_LEG];

    logic signed [IW-1:0]      r4_w;
    logic signed [IW-1:0]      lo_w [NUM_LEG];
    logic signed [IW-1:0]      hi_w [NUM_LEG];
    logic signed [IW-1:0]      hr_w [NUM_LEG];
    logic signed [W-1:0]       mva  [NUM_LEG];
    logic signed [W-1:0]       mvb  [NUM_LEG];
    logic signed [W-1:0]       ha_w, hb_w, r4_sat;
    logic [NUM_LEG*W-1:0]      va_w, vb_w;
    logic [NUM_LEG-1:0]        en_a_w, en_b_w;
    logic                      accept;

    assign accept = in_valid && (state == ST_IDLE);
    assign ha_w   = $signed(vca_q) >>> 1;
    assign hb_w   = $signed(vcb_q) >>> 1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ST_VR4;
            ST_VR4:                 state_nx = ST_VRK;
            ST_VRK:                 state_nx = ST_BND;
            ST_BND:                 state_nx = ST_MIX;
            ST_MIX:                 state_nx = ST_OUT;
            ST_OUT: if (out_ready)  state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // handshake outputs
    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_OUT);
    end

    dual_inv_vr4 #(.W(W), .IW(IW), .MUW(MUW)) u_vr4 (
        .mode (mode_q),
        .vp   (vp_q),
        .vca  (vca_q),
        .vcb  (vcb_q),
        .mu   (mur4_q),
        .r4   (r4_w)
    );

    for (genvar k = 0; k < NUM_LEG; k++) begin : g_leg
        dual_inv_leg_bounds #(.W(W), .IW(IW)) u_bnd (
            .rk (rk_q[k]),
            .ha (ha_w),
            .hb (hb_w),
            .hr (hr_w[k]),
            .lo (lo_w[k]),
            .hi (hi_w[k])
        );
        dual_inv_leg_mix #(.W(W), .IW(IW), .MUW(MUW)) u_mix (
            .lo (lo_q[k]),
            .hi (hi_q[k]),
            .hr (hr_q[k]),
            .mu (mux_q[k*MUW +: MUW]),
            .ha (ha_w),
            .hb (hb_w),
            .va (mva[k]),
            .vb (mvb[k])
        );
    end

    // leg-4 override and enables per mode
    always_comb begin
        if (r4_q > IW'(ha_w))       r4_sat = ha_w;
        else if (r4_q < -IW'(ha_w)) r4_sat = -ha_w;
        else                        r4_sat = W'(r4_q);
        for (int k = 0; k < NUM_LEG; k++) begin
            va_w[k*W +: W] = mva[k];
            vb_w[k*W +: W] = mvb[k];
        end
        unique case (mode_q)
            MD_FOUR_FOUR: begin
                en_a_w = 4'b1111;
                en_b_w = 4'b1111;
            end
            MD_FOUR_SPLIT: begin
                en_a_w = 4'b1111;
                en_b_w = 4'b0111;
                va_w[3*W +: W] = r4_sat;
                vb_w[3*W +: W] = '0;
            end
            MD_SPLIT_SPLIT, MD_SPLIT_ALT: begin
                en_a_w = 4'b0111;
                en_b_w = 4'b0111;
                va_w[3*W +: W] = '0;
                vb_w[3*W +: W] = '0;
            end
            default: begin
                en_a_w = '0;
                en_b_w = '0;
            end
        endcase
    end

    // datapath stage registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MD_FOUR_FOUR;
            vp_q     <= '0;
            vca_q    <= '0;
            vcb_q    <= '0;
            mur4_q   <= '0;
            mux_q    <= '0;
            r4_q     <= '0;
            va_ref   <= '0;
            vb_ref   <= '0;
            leg_en_a <= '0;
            leg_en_b <= '0;
            for (int k = 0; k < NUM_LEG; k++) begin
                rk_q[k] <= '0;
                lo_q[k] <= '0;
                hi_q[k] <= '0;
                hr_q[k] <= '0;
            end
        end else begin
            if (accept) begin
                mode_q <= leg_mode_t'(mode);
                vp_q   <= vp_ref;
                vca_q  <= vdc_a;
                vcb_q  <= vdc_b;
                mur4_q <= mu_r4;
                mux_q  <= mu_x;
            end
            if (state == ST_VR4) begin
                r4_q <= r4_w;
            end
            if (state == ST_VRK) begin
                for (int k = 0; k < NUM_PHASE; k++) begin
                    rk_q[k] <= IW'($signed(vp_q[k*W +: W])) + r4_q;
                end
                rk_q[NUM_LEG-1] <= r4_q;
            end
            if (state == ST_BND) begin
                for (int k = 0; k < NUM_LEG; k++) begin
                    lo_q[k] <= lo_w[k];
                    hi_q[k] <= hi_w[k];
                    hr_q[k] <= hr_w[k];
                end
            end
            if (state == ST_MIX) begin
                va_ref   <= va_w;
                vb_ref   <= vb_w;
                leg_en_a <= en_a_w;
                leg_en_b <= en_b_w;
            end
        end
    end
endmodule

// File: rtl/dual_inv_pole_ref_chk.sv
module dual_inv_pole_ref_chk #(
    parameter int W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       mode,
    input logic [W-1:0]     vdc_a,
    input logic [W-1:0]     vdc_b,
    input logic             out_valid,
    input logic             out_ready,
    input logic [4*W-1:0]   va_ref,
    input logic [4*W-1:0]   vb_ref,
    input logic [3:0]       leg_en_a,
    input logic [3:0]       leg_en_b
);
    logic signed [W-1:0] cap_ha, cap_hb;
    logic [1:0]          cap_mode;
    logic [3:0]          exp_en_a, exp_en_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ha   <= '0;
            cap_hb   <= '0;
            cap_mode <= '0;
        end else if (in_valid && in_ready) begin
            cap_ha   <= $signed(vdc_a) >>> 1;
            cap_hb   <= $signed(vdc_b) >>> 1;
            cap_mode <= mode;
        end
    end

    always_comb begin
        exp_en_a = (cap_mode[1]) ? 4'b0111 : 4'b1111;
        exp_en_b = (cap_mode == 2'd0) ? 4'b1111 : 4'b0111;
    end

    a_r2_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(va_ref) && $stable(vb_ref)));

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##5 $rose(out_valid));

    a_r11_enables: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (leg_en_a == exp_en_a && leg_en_b == exp_en_b));

    a_r10_leg4_a_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !leg_en_a[3]) |-> (va_ref[3*W +: W] == '0));

    a_r10_leg4_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !leg_en_b[3]) |-> (vb_ref[3*W +: W] == '0));

    for (genvar k = 0; k < 4; k++) begin : g_lim
        a_r9_va_limit: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($signed(va_ref[k*W +: W]) <= cap_ha &&
                           $signed(va_ref[k*W +: W]) >= -cap_ha));
        a_r9_vb_limit: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($signed(vb_ref[k*W +: W]) <= cap_hb &&
                           $signed(vb_ref[k*W +: W]) >= -cap_hb));
    end
endmodule

bind dual_inv_pole_ref dual_inv_pole_ref_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mode      (mode),
    .vdc_a     (vdc_a),
    .vdc_b     (vdc_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .va_ref    (va_ref),
    .vb_ref    (vb_ref),
    .leg_en_a  (leg_en_a),
    .leg_en_b  (leg_en_b)
);

// File: tb/dual_inv_pole_ref_test.sv
module dual_inv_pole_ref_test;
    localparam int W   = 16;
    localparam int MUW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [1:0]        mode = '0;
    logic [3*W-1:0]    vp_ref = '0;
    logic [W-1:0]      vdc_a = '0;
    logic [W-1:0]      vdc_b = '0;
    logic [MUW-1:0]    mu_r4 = '0;
    logic [4*MUW-1:0]  mu_x = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [4*W-1:0]    va_ref, vb_ref;
    logic [3:0]        leg_en_a, leg_en_b;

    always #5 clk = ~clk;

    dual_inv_pole_ref #(.W(W), .MUW(MUW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .vp_ref(vp_ref), .vdc_a(vdc_a), .vdc_b(vdc_b),
        .mu_r4(mu_r4), .mu_x(mu_x), .out_valid(out_valid), .out_ready(out_ready),
        .va_ref(va_ref), .vb_ref(vb_ref), .leg_en_a(leg_en_a), .leg_en_b(leg_en_b)
    );

    typedef struct {
        longint va [4];
        longint vb [4];
        logic [3:0] ea;
        logic [3:0] eb;
        longint acc;
        string  tag;
    } exp_t;

    exp_t   sb [$];
    int     n_tests = 0;
    int     n_fail  = 0;
    longint cyc = 0;
    bit     stall = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint interp_m(longint lo, longint hi, longint mu);
        if (mu == 65535) return hi;
        return lo + ((mu * (hi - lo)) >>> 16);
    endfunction

    function automatic longint sat_m(longint v, longint lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    function automatic longint min2(longint a, longint b);
        return (a < b) ? a : b;
    endfunction

    function automatic longint max2(longint a, longint b);
        return (a > b) ? a : b;
    endfunction

    // reference model written from R4..R11
    task automatic model(input int md, input longint p [3], input longint vca, input longint vcb,
                         input longint mr4, input longint mx [4], output exp_t e);
        longint ha, hb, avg, mn, mx_, lo, hi, r4, h, x;
        longint rk [4];
        ha  = vca >>> 1;
        hb  = vcb >>> 1;
        avg = (vca + vcb) >>> 1;
        mn  = min2(p[0], min2(p[1], p[2]));
        mx_ = max2(p[0], max2(p[1], p[2]));
        if (md == 0) begin                        // R5
            mn  = min2(mn, 0);
            mx_ = max2(mx_, 0);
            r4  = interp_m(-avg - mn, avg - mx_, mr4);
        end else if (md == 1) begin               // R6
            lo = max2(-avg - mn, -ha);
            hi = min2(avg - mx_, ha);
            r4 = interp_m(lo, hi, mr4);
        end else begin
            r4 = 0;                               // R7
        end
        for (int k = 0; k < 3; k++) rk[k] = p[k] + r4;
        rk[3] = r4;
        for (int k = 0; k < 4; k++) begin         // R8, R9
            h  = rk[k] >>> 1;
            lo = max2(-ha - h, -hb + h);
            hi = min2(ha - h, hb + h);
            x  = interp_m(lo, hi, mx[k]);
            e.va[k] = sat_m(h + x, ha);
            e.vb[k] = sat_m(x - h, hb);
        end
        if (md == 0) begin                        // R10, R11
            e.ea = 4'b1111; e.eb = 4'b1111;
        end else if (md == 1) begin
            e.ea = 4'b1111; e.eb = 4'b0111;
            e.va[3] = sat_m(r4, ha); e.vb[3] = 0;
        end else begin
            e.ea = 4'b0111; e.eb = 4'b0111;
            e.va[3] = 0; e.vb[3] = 0;
        end
    endtask

    task automatic send(input int md, input int p1, input int p2, input int p3,
                        input int vca, input int vcb, input int mr4,
                        input int m0, input int m1, input int m2, input int m3,
                        input string tag);
        exp_t e;
        longint pp [3];
        longint mm [4];
        pp[0] = p1; pp[1] = p2; pp[2] = p3;
        mm[0] = m0; mm[1] = m1; mm[2] = m2; mm[3] = m3;
        model(md, pp, vca, vcb, mr4, mm, e);
        e.tag = tag;
        @(posedge clk); #1;
        mode     = 2'(md);
        vp_ref   = {W'(p3), W'(p2), W'(p1)};
        vdc_a    = W'(vca);
        vdc_b    = W'(vcb);
        mu_r4    = MUW'(mr4);
        mu_x     = {MUW'(m3), MUW'(m2), MUW'(m1), MUW'(m0)};
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) begin
            @(posedge clk); #1;
            @(negedge clk);
        end
        e.acc = cyc;
        sb.push_back(e);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b0, "R2", {tag, " in_ready while busy"}, longint'(in_ready), 0);
    endtask

    // consumer ready pattern
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = stall ? (cyc % 3 == 0) : 1'b1;
        end
    end

    // monitor: pops the scoreboard as results appear
    initial begin
        bit held;
        logic [4*W-1:0] hva, hvb;
        exp_t e;
        held = 1'b0;
        hva = '0;
        hvb = '0;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2", "result with nothing accepted", 1, 0);
                end else begin
                    e = sb[0];
                    if (!held) begin
                        chk(cyc - e.acc == 5, "R3", {e.tag, " latency"}, cyc - e.acc, 5);
                    end else begin
                        chk(va_ref == hva && vb_ref == hvb, "R2", {e.tag, " hold under backpressure"},
                            longint'(va_ref[W-1:0]), longint'(hva[W-1:0]));
                    end
                    if (out_ready) begin
                        for (int k = 0; k < 4; k++) begin
                            chk(longint'($signed(va_ref[k*W +: W])) == e.va[k], "R8",
                                $sformatf("%s va leg%0d", e.tag, k + 1),
                                longint'($signed(va_ref[k*W +: W])), e.va[k]);
                            chk(longint'($signed(vb_ref[k*W +: W])) == e.vb[k], "R8",
                                $sformatf("%s vb leg%0d", e.tag, k + 1),
                                longint'($signed(vb_ref[k*W +: W])), e.vb[k]);
                        end
                        chk(leg_en_a == e.ea && leg_en_b == e.eb, "R11", {e.tag, " enables"},
                            longint'({leg_en_a, leg_en_b}), longint'({e.ea, e.eb}));
                        void'(sb.pop_front());
                        held = 1'b0;
                    end else begin
                        held = 1'b1;
                        hva  = va_ref;
                        hvb  = vb_ref;
                    end
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog expired: actual %0d expected %0d", cyc, 20000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready", longint'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);
        chk(va_ref == '0 && vb_ref == '0, "R1", "pole outputs", longint'(va_ref[W-1:0]), 0);
        chk(leg_en_a == '0 && leg_en_b == '0, "R1", "enables", longint'({leg_en_a, leg_en_b}), 0);

        // R4, R5: four/four mode, weight end points and mid point
        send(0, 1000, -500, -500, 4000, 2000, 0, 0, 0, 0, 0, "ff_mu_zero");
        send(0, 1000, -500, -500, 4000, 2000, 65535, 65535, 65535, 65535, 65535, "ff_mu_full");
        send(0, 1000, -500, -500, 4000, 2000, 32768, 32768, 32768, 32768, 32768, "ff_mu_half");
        send(0, 3000, -1500, -1500, 2000, 4000, 16384, 49152, 8000, 60000, 1234, "ff_unequal");
        send(0, 1001, -333, 7, 3001, 1999, 12345, 777, 40000, 65534, 1, "ff_odd");
        // R6, R10: four/split mode, including the ±ha clamp on the r4 bounds
        send(1, 800, 200, -1000, 6000, 3000, 32768, 20000, 30000, 40000, 50000, "fs_mid");
        send(1, 100, 50, 0, 1000, 9000, 65535, 32768, 32768, 32768, 32768, "fs_clamp_hi");
        send(1, -100, -50, -20, 1000, 9000, 0, 0, 65535, 100, 5000, "fs_clamp_lo");
        // R7, R10: split/split modes, code 2 and code 3
        send(2, 1200, -300, -900, 5000, 2500, 40000, 10000, 20000, 30000, 65535, "ss_mode2");
        send(3, 1200, -300, -900, 5000, 2500, 40000, 10000, 20000, 30000, 65535, "ss_mode3");
        // R9: infeasible demands force the output clamp
        send(0, 20000, -20000, 0, 4000, 4000, 32768, 0, 65535, 32768, 32768, "ff_saturate");
        send(0, -32768, 32767, 0, 32767, 32767, 65535, 65535, 0, 32768, 12345, "ff_extreme");
        send(1, 30000, -30000, 5, 0, 0, 32768, 32768, 32768, 32768, 32768, "fs_zero_link");

        // R2: back-to-back with a consumer that stalls
        stall = 1'b1;
        send(0, 2000, -1000, -1000, 6000, 3000, 10000, 20000, 30000, 40000, 50000, "bp_ff");
        send(1, -700, 300, 400, 5000, 5000, 60000, 1000, 2000, 3000, 4000, "bp_fs");
        send(2, 900, -900, 0, 3000, 6000, 0, 65535, 0, 65535, 0, "bp_ss");
        send(0, -1500, 750, 750, 8000, 2000, 32768, 32768, 100, 65000, 32768, "bp_ff2");

        while (sb.size() != 0) @(posedge clk);
        stall = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R2", "idle after drain",
            longint'({out_valid, in_ready}), 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule